// File: doc/BRIEF.md
# PPS-Aligned Block Sequence Numberer

This block cuts time into fixed-length sample blocks and attaches a 64-bit sequence number to each one. Software writes a starting sequence number and a sync-interval length, then arms the block. Output begins on the first rising edge of the pulse-per-second input after arming. From then on, blocks follow each other back to back. Each block is marked with a start flag on its first cycle and an end flag on its last cycle. Its sequence number is held for the whole block. A sync flag marks the first cycle of every block that opens a new sync interval.

Stopping is clean. A disable written while the block is streaming lets the block in progress run to its last sample. Output then goes quiet on a block boundary, so a downstream FIFO never holds a partial block.

The control flow is a four-state machine:
- IDLE: no output.
- ARMED: waiting for a PPS rising edge.
- RUN: streaming blocks.
- DRAIN: finishing the current block after a disable.

The transitions are:
- arm: IDLE to ARMED, on a write of 3 to the control word.
- cancel: ARMED to IDLE, on a write of 0.
- launch: ARMED to RUN, on a PPS rising edge.
- stop: RUN to DRAIN, on a write of 0 that lands before the final sample.
- halt: RUN to IDLE, on a write of 0 that lands on the final sample.
- done: DRAIN to IDLE, at the end of the block.

Top module: `bsn_seq`

## Requirements
- R1: After reset all outputs are 0 and the block is in IDLE. Address 0 reads 0, address 1 reads BLOCK_LEN*SYNC_BLOCKS, and addresses 2 and 3 read 0.
- R2: A write to address 2 only stores a low word. A write to address 3 loads the initial sequence number as {address-3 data, stored low word}. A later address-2 write alone does not change the initial value.
- R3: A write to address 0 whose bits [1:0] are 3 arms the block from IDLE. The first valid cycle, with the start flag set, comes in the cycle after the clock edge at which an armed block first samples PPS high while the previous sample was low. A PPS pulse while IDLE produces no output.
- R4: While streaming, out_valid is high without gaps. Blocks are BLOCK_LEN cycles long, with out_sop on the first cycle and out_eop on the last.
- R5: The first block carries the initial sequence number. Each following block carries one more. out_bsn is constant within a block.
- R6: Address 1 sets S, a cycle count that restarts at 0 at launch and wraps after S cycles. out_sync is high on a start cycle whose count is 0. An S of 0 or 1 puts sync on every block.
- R7: A PPS edge while streaming neither restarts the block nor changes the sequence number.
- R8: A write with bits [1:0] equal to 0 at address 0 does the following:
  - In ARMED, it returns the block to IDLE at once.
  - In RUN, it lets the current block finish through its end cycle, after which out_valid stays low.
  - A write of 3 during DRAIN is ignored.
- R9: mm_rdata is valid in the cycle after mm_rd. The addresses read as follows:
  - Address 0 reads 3 in ARMED or RUN, and 0 otherwise.
  - Address 1 reads S.
  - Addresses 2 and 3 read the low and high words of the current sequence number.
- R10: Re-arming after a stop restarts at the next PPS edge with the initial sequence number, and the sync count starts again from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pps | input | 1 | Pulse-per-second input, rising edge used |
| mm_wr | input | 1 | Register write strobe |
| mm_rd | input | 1 | Register read strobe |
| mm_addr | input | 2 | Register address |
| mm_wdata | input | 32 | Write data |
| mm_rdata | output | 32 | Read data, one cycle after mm_rd |
| out_valid | output | 1 | Block sample cycle |
| out_sop | output | 1 | First cycle of a block |
| out_eop | output | 1 | Last cycle of a block |
| out_sync | output | 1 | First cycle of a sync-interval block |
| out_bsn | output | 64 | Sequence number of the current block |

## Verification
A wrong state shows up on out_valid within one cycle. Examples are a launch without PPS, a missed cancel, or a drain that ends early or late. A sample counter that slips moves out_sop or out_eop off the BLOCK_LEN grid in the first block it touches. A bad sequence or sync counter shows up at the next start cycle. The bench runs a behavioural model and compares every output on every clock, so each of these faults is caught in the first cycle it becomes visible.

// File: rtl/bsn_seq_pkg.sv
package bsn_seq_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned BSN_W  = 64;
    localparam int unsigned REG_AW = 2;

    localparam logic [REG_AW-1:0] REG_CTRL   = 2'd0;
    localparam logic [REG_AW-1:0] REG_SYNC   = 2'd1;
    localparam logic [REG_AW-1:0] REG_BSN_LO = 2'd2;
    localparam logic [REG_AW-1:0] REG_BSN_HI = 2'd3;

    localparam logic [1:0] CTRL_ARM  = 2'b11;
    localparam logic [1:0] CTRL_STOP = 2'b00;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_RUN,
        ST_DRAIN
    } seq_state_t;
endpackage

// File: rtl/bsn_seq_regs.sv
module bsn_seq_regs
    import bsn_seq_pkg::*;
#(
    parameter int unsigned SYNC_RST = 7168
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mm_wr,
    input  logic              mm_rd,
    input  logic [REG_AW-1:0] mm_addr,
    input  logic [WORD_W-1:0] mm_wdata,
    input  logic              enabled,
    input  logic [BSN_W-1:0]  cur_bsn,
    output logic [WORD_W-1:0] mm_rdata,
    output logic [WORD_W-1:0] sync_cycles,
    output logic [BSN_W-1:0]  init_bsn,
    output logic              arm_req,
    output logic              stop_req
);
    localparam int unsigned HI_W = BSN_W - WORD_W;

    logic [WORD_W-1:0] low_hold;
    logic              ctrl_wr;

    assign ctrl_wr  = mm_wr && (mm_addr == REG_CTRL);
    assign arm_req  = ctrl_wr && (mm_wdata[1:0] == CTRL_ARM);
    assign stop_req = ctrl_wr && (mm_wdata[1:0] == CTRL_STOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_cycles <= WORD_W'(SYNC_RST);
            low_hold    <= '0;
            init_bsn    <= '0;
        end else if (mm_wr) begin
            unique case (mm_addr)
                REG_SYNC:   sync_cycles <= mm_wdata;
                REG_BSN_LO: low_hold    <= mm_wdata;
                REG_BSN_HI: init_bsn    <= {mm_wdata[HI_W-1:0], low_hold};
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mm_rdata <= '0;
        end else if (mm_rd) begin
            unique case (mm_addr)
                REG_CTRL:   mm_rdata <= enabled ? WORD_W'(CTRL_ARM) : '0;
                REG_SYNC:   mm_rdata <= sync_cycles;
                REG_BSN_LO: mm_rdata <= cur_bsn[WORD_W-1:0];
                default:    mm_rdata <= WORD_W'(cur_bsn[BSN_W-1:WORD_W]);
            endcase
        end
    end
endmodule

// File: rtl/bsn_seq_fsm.sv
module bsn_seq_fsm
    import bsn_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       arm_req,
    input  logic       stop_req,
    input  logic       pps_rise,
    input  logic       blk_last,
    output seq_state_t state,
    output logic       start,
    output logic       active,
    output logic       run_next,
    output logic       enabled
);
    seq_state_t nxt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // transitions: arm, cancel, launch, stop, halt, done
    always_comb begin
        nxt   = state;
        start = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (arm_req) nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (stop_req) begin
                    nxt = ST_IDLE;
                end else if (pps_rise) begin
                    nxt   = ST_RUN;
                    start = 1'b1;
                end
            end
            ST_RUN: begin
                if (stop_req) nxt = blk_last ? ST_IDLE : ST_DRAIN;
            end
            ST_DRAIN: begin
                if (blk_last) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        active   = (state == ST_RUN)  || (state == ST_DRAIN);
        run_next = (nxt == ST_RUN)    || (nxt == ST_DRAIN);
        enabled  = (state == ST_ARMED) || (state == ST_RUN);
    end
endmodule

// File: rtl/bsn_seq_count.sv
module bsn_seq_count
    import bsn_seq_pkg::*;
#(
    parameter int unsigned BLOCK_LEN = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              active,
    input  logic              run_next,
    input  logic [BSN_W-1:0]  init_bsn,
    input  logic [WORD_W-1:0] sync_cycles,
    output logic              blk_first,
    output logic              blk_last,
    output logic              sync_zero,
    output logic [BSN_W-1:0]  bsn
);
    localparam int unsigned SAMP_W = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1;
    localparam logic [SAMP_W-1:0] SAMP_LAST = SAMP_W'(BLOCK_LEN - 1);

    logic [SAMP_W-1:0] samp;
    logic [WORD_W-1:0] sync_cnt;
    logic [WORD_W:0]   sync_inc;
    logic              sync_wrap;

    assign sync_inc  = {1'b0, sync_cnt} + 1'b1;
    assign sync_wrap = sync_inc >= {1'b0, sync_cycles};

    always_ff @(posedge clk) begin
        if (rst) begin
            samp     <= '0;
            sync_cnt <= '0;
            bsn      <= '0;
        end else if (start) begin
            samp     <= '0;
            sync_cnt <= '0;
            bsn      <= init_bsn;
        end else if (active) begin
            samp     <= blk_last  ? '0 : samp + 1'b1;
            sync_cnt <= sync_wrap ? '0 : sync_inc[WORD_W-1:0];
            if (blk_last && run_next) bsn <= bsn + 1'b1;
        end
    end

    assign blk_first = (samp == '0);
    assign blk_last  = (samp == SAMP_LAST);
    assign sync_zero = (sync_cnt == '0);
endmodule

// File: rtl/bsn_seq.sv
module bsn_seq
    import bsn_seq_pkg::*;
#(
    parameter int unsigned BLOCK_LEN   = 1024,
    parameter int unsigned SYNC_BLOCKS = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pps,
    input  logic        mm_wr,
    input  logic        mm_rd,
    input  logic [1:0]  mm_addr,
    input  logic [31:0] mm_wdata,
    output logic [31:0] mm_rdata,
    output logic        out_valid,
    output logic        out_sop,
    output logic        out_eop,
    output logic        out_sync,
    output logic [63:0] out_bsn
);
    localparam int unsigned SYNC_RST = BLOCK_LEN * SYNC_BLOCKS;

    seq_state_t        state;
    logic              pps_q, pps_rise;
    logic              start, active, run_next, enabled;
    logic              arm_req, stop_req;
    logic              blk_first, blk_last, sync_zero;
    logic [WORD_W-1:0] sync_cycles;
    logic [BSN_W-1:0]  init_bsn, bsn;

    always_ff @(posedge clk) begin
        if (rst) pps_q <= 1'b0;
        else     pps_q <= pps;
    end
    assign pps_rise = pps && !pps_q;

    bsn_seq_regs #(.SYNC_RST(SYNC_RST)) i_regs (
        .clk(clk), .rst(rst), .mm_wr(mm_wr), .mm_rd(mm_rd), .mm_addr(mm_addr),
        .mm_wdata(mm_wdata), .enabled(enabled), .cur_bsn(bsn), .mm_rdata(mm_rdata),
        .sync_cycles(sync_cycles), .init_bsn(init_bsn), .arm_req(arm_req), .stop_req(stop_req)
    );

    bsn_seq_fsm i_fsm (
        .clk(clk), .rst(rst), .arm_req(arm_req), .stop_req(stop_req), .pps_rise(pps_rise),
        .blk_last(blk_last), .state(state), .start(start), .active(active),
        .run_next(run_next), .enabled(enabled)
    );

    bsn_seq_count #(.BLOCK_LEN(BLOCK_LEN)) i_count (
        .clk(clk), .rst(rst), .start(start), .active(active), .run_next(run_next),
        .init_bsn(init_bsn), .sync_cycles(sync_cycles), .blk_first(blk_first),
        .blk_last(blk_last), .sync_zero(sync_zero), .bsn(bsn)
    );

    always_comb begin
        out_valid = active;
        out_sop   = active && blk_first;
        out_eop   = active && blk_last;
        out_sync  = active && blk_first && sync_zero;
        out_bsn   = bsn;
    end
endmodule

// File: rtl/bsn_seq_chk.sv
module bsn_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        pps,
    input logic        out_valid,
    input logic        out_sop,
    input logic        out_eop,
    input logic        out_sync,
    input logic [63:0] out_bsn
);
    // R4
    sop_in_block_chk: assert property (@(posedge clk) disable iff (rst)
        (out_sop || out_eop) |-> out_valid);
    // R4
    mid_block_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eop) |=> (out_valid && !out_sop));
    // R4
    block_edge_chk: assert property (@(posedge clk) disable iff (rst)
        out_eop |=> (!out_valid || out_sop));
    // R5
    bsn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eop) |=> $stable(out_bsn));
    // R5
    bsn_step_chk: assert property (@(posedge clk) disable iff (rst)
        out_eop |=> (!out_valid || (out_bsn == $past(out_bsn) + 64'd1)));
    // R6
    sync_on_sop_chk: assert property (@(posedge clk) disable iff (rst)
        out_sync |-> out_sop);
    // R3
    start_on_pps_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (out_sop && $past(pps)));
endmodule

bind bsn_seq bsn_seq_chk i_bsn_seq_chk (
    .clk(clk), .rst(rst), .pps(pps), .out_valid(out_valid), .out_sop(out_sop),
    .out_eop(out_eop), .out_sync(out_sync), .out_bsn(out_bsn)
);

// File: tb/test_bsn_seq.sv
`timescale 1ns/1ps
module test_bsn_seq;
    localparam int BL = 8;
    localparam int SB = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pps = 1'b0;
    logic        mm_wr = 1'b0, mm_rd = 1'b0;
    logic [1:0]  mm_addr = '0;
    logic [31:0] mm_wdata = '0;
    logic [31:0] mm_rdata;
    logic        out_valid, out_sop, out_eop, out_sync;
    logic [63:0] out_bsn;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    bsn_seq #(.BLOCK_LEN(BL), .SYNC_BLOCKS(SB)) i_bsn_seq (
        .clk(clk), .rst(rst), .pps(pps), .mm_wr(mm_wr), .mm_rd(mm_rd), .mm_addr(mm_addr),
        .mm_wdata(mm_wdata), .mm_rdata(mm_rdata), .out_valid(out_valid), .out_sop(out_sop),
        .out_eop(out_eop), .out_sync(out_sync), .out_bsn(out_bsn)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model: 0 idle, 1 armed, 2 run, 3 drain
    int          m_state;
    int          m_samp;
    longint      m_sync, m_syncc;
    logic [63:0] m_bsn, m_init;
    logic [31:0] m_low, m_rdata;
    bit          m_pps_prev;

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_samp = 0; m_sync = 0; m_syncc = BL * SB;
            m_bsn = 0; m_init = 0; m_low = 0; m_rdata = 0; m_pps_prev = 0;
        end else begin
            bit was_valid, last, rise, arm, stop;
            if (mm_rd) begin
                case (mm_addr)
                    2'd0: m_rdata = (m_state == 1 || m_state == 2) ? 32'd3 : 32'd0;
                    2'd1: m_rdata = 32'(m_syncc);
                    2'd2: m_rdata = m_bsn[31:0];
                    default: m_rdata = m_bsn[63:32];
                endcase
            end
            was_valid = (m_state >= 2);
            last = was_valid && (m_samp == BL - 1);
            rise = pps && !m_pps_prev;
            m_pps_prev = pps;
            arm  = mm_wr && mm_addr == 2'd0 && mm_wdata[1:0] == 2'b11;
            stop = mm_wr && mm_addr == 2'd0 && mm_wdata[1:0] == 2'b00;
            if (was_valid) begin
                m_samp = last ? 0 : m_samp + 1;
                m_sync = (m_sync + 1 >= m_syncc) ? 0 : m_sync + 1;
            end
            case (m_state)
                0: if (arm) m_state = 1;
                1: if (stop) m_state = 0;
                   else if (rise) begin
                       m_state = 2; m_samp = 0; m_sync = 0; m_bsn = m_init;
                   end
                2: if (stop) m_state = last ? 0 : 3;
                   else if (last) m_bsn = m_bsn + 1;
                default: if (last) m_state = 0;
            endcase
            if (mm_wr) begin
                case (mm_addr)
                    2'd1: m_syncc = longint'(mm_wdata);
                    2'd2: m_low = mm_wdata;
                    2'd3: m_init = {mm_wdata, m_low};
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            bit ev, es, ee, ey;
            ev = (m_state >= 2);
            es = ev && m_samp == 0;
            ee = ev && m_samp == BL - 1;
            ey = es && m_sync == 0;
            check(out_valid == ev, "R4 valid", 64'(out_valid), 64'(ev));
            check(out_sop == es, "R4 sop", 64'(out_sop), 64'(es));
            check(out_eop == ee, "R4 eop", 64'(out_eop), 64'(ee));
            check(out_sync == ey, "R6 sync", 64'(out_sync), 64'(ey));
            if (ev) check(out_bsn == m_bsn, "R5 bsn", out_bsn, m_bsn);
            check(mm_rdata == m_rdata, "R9 rdata", 64'(mm_rdata), 64'(m_rdata));
        end
    end

    task automatic tick(); @(negedge clk); endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        mm_wr = 1'b1; mm_addr = a; mm_wdata = d;
        tick();
        mm_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        mm_rd = 1'b1; mm_addr = a;
        tick();
        mm_rd = 1'b0;
        d = mm_rdata;
    endtask

    task automatic pulse_pps();
        pps = 1'b1;
        tick();
        pps = 1'b0;
    endtask

    task automatic wait_sop();
        for (int i = 0; i < 100; i++) begin
            tick();
            if (out_sop) break;
        end
    endtask

    task automatic wait_eop();
        for (int i = 0; i < 100; i++) begin
            if (out_eop) break;
            tick();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R4 watchdog", 64'd0, 64'd1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1
        check(!out_valid && !out_sop && !out_sync && out_bsn == 0, "R1 reset outputs", out_bsn, 64'd0);
        rd(2'd0, d); check(d == 0, "R1 ctrl read", 64'(d), 64'd0);
        rd(2'd1, d); check(d == BL * SB, "R1 sync read", 64'(d), 64'(BL * SB));
        rd(2'd2, d); check(d == 0, "R1 bsn read", 64'(d), 64'd0);
        // R3 pps while idle
        pulse_pps(); repeat (3) tick();
        check(!out_valid, "R3 idle pps ignored", 64'(out_valid), 64'd0);

        wr(2'd1, 32'd24);
        wr(2'd2, 32'd5);
        wr(2'd3, 32'd1);
        wr(2'd2, 32'h99);
        wr(2'd0, 32'd3);
        rd(2'd0, d); check(d == 3, "R9 armed read", 64'(d), 64'd3);
        repeat (2) tick();
        check(!out_valid, "R3 armed waits", 64'(out_valid), 64'd0);
        pulse_pps();
        check(out_valid && out_sop, "R3 launch", 64'(out_sop), 64'd1);
        check(out_bsn == 64'h1_0000_0005, "R2 initial bsn", out_bsn, 64'h1_0000_0005);
        check(out_sync, "R6 first sync", 64'(out_sync), 64'd1);
        tick();
        pulse_pps();
        check(out_valid && !out_sop && out_bsn == 64'h1_0000_0005, "R7 pps while running", 64'(out_sop), 64'd0);
        wait_sop();
        check(!out_sync && out_bsn == 64'h1_0000_0006, "R5 second block", out_bsn, 64'h1_0000_0006);
        wait_sop();
        wait_sop();
        check(out_sync && out_bsn == 64'h1_0000_0008, "R6 sync after 3 blocks", out_bsn, 64'h1_0000_0008);
        rd(2'd2, d); check(d == 32'h8, "R9 bsn low", 64'(d), 64'h8);
        rd(2'd3, d); check(d == 32'h1, "R9 bsn high", 64'(d), 64'h1);
        wr(2'd0, 32'd0);
        wr(2'd0, 32'd3);
        n = 0;
        while (out_valid && n < 100) begin n++; tick(); end
        check(n == BL - 4, "R8 drain completes block", 64'(n), 64'(BL - 4));
        repeat (3) tick();
        check(!out_valid, "R8 stays stopped", 64'(out_valid), 64'd0);
        rd(2'd0, d); check(d == 0, "R8 arm in drain ignored", 64'(d), 64'd0);

        wr(2'd3, 32'd0);
        wr(2'd1, 32'd0);
        wr(2'd0, 32'd3);
        wr(2'd0, 32'd0);
        pulse_pps(); repeat (2) tick();
        check(!out_valid, "R8 cancel while armed", 64'(out_valid), 64'd0);
        wr(2'd0, 32'd3);
        tick();
        pulse_pps();
        check(out_sop && out_sync && out_bsn == 64'h99, "R10 restart bsn", out_bsn, 64'h99);
        wait_sop();
        check(out_sync && out_bsn == 64'h9A, "R6 zero period sync", out_bsn, 64'h9A);
        wait_eop();
        wr(2'd0, 32'd0);
        check(!out_valid, "R8 stop on eop", 64'(out_valid), 64'd0);
        rd(2'd2, d); check(d == 32'h9A, "R9 bsn held", 64'(d), 64'h9A);

        wr(2'd1, 32'd20);
        wr(2'd0, 32'd3);
        pulse_pps();
        repeat (6) wait_sop();
        wr(2'd0, 32'd0);
        repeat (2 * BL) tick();
        check(!out_valid, "R8 final stop", 64'(out_valid), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule